// File: doc/BRIEF.md
# Effective Address Generator

This unit forms the memory offset of an operand from already decoded fields. It supports a narrow 16-bit mode and a wide 32-bit mode. Each request names an optional base register, an optional index register with a scale code, and a displacement with a size code. The unit reads both selected registers through a combinational register-file read interface and adds base, scaled index and sign-extended displacement. The sum wraps at the width of the active mode.

Alongside the offset, the unit reports which default segment the access uses, data or stack. The choice follows from the base register. The unit also raises an illegal flag when a register or scale choice breaks the rules of the active mode. Results are registered and appear in the cycle after the input strobe. They then hold until the next strobe.

General registers are coded 0..7 as A, C, D, B, SP, BP, SI, DI.

Top module: `addr_gen_unit`

## Requirements
- R1: In the cycle after `in_valid` is high, `out_valid` is 1 and `ea`, `seg_stack` and `illegal` show the result for the inputs present at that strobe. In any cycle after `in_valid` was low, `out_valid` is 0 and the three result outputs keep their values. After reset, all outputs are 0.
- R2: In 32-bit mode, `ea` = base + scaled index + displacement, modulo 2^32. A base with `base_vld`=0 or an index with `index_vld`=0 contributes zero.
- R3: `disp_size` selects the displacement as follows. 0 gives zero. 1 gives bits 7:0 sign-extended. 2 gives bits 15:0 sign-extended. 3 gives all 32 bits.
- R4: In 32-bit mode, scale codes 0, 1, 2 and 3 multiply the index value by 1, 2, 4 and 8.
- R5: In 16-bit mode, a present base other than B (3) or BP (5) is illegal. A present index other than SI (6) or DI (7) is also illegal.
- R6: In 16-bit mode, a nonzero scale code is illegal. The sum uses the low 16 bits of each register, wraps modulo 2^16, and `ea[31:16]` is 0.
- R7: In 32-bit mode, any base code is legal. An index with code 4 (SP) is illegal.
- R8: In 32-bit mode, a legal request gives `seg_stack`=1 exactly when a base is present with code 4 or 5.
- R9: In 16-bit mode, a legal request gives `seg_stack`=1 exactly when a base is present with code 5.
- R10: When no base is present, `seg_stack` is 0, even when the index code is 5.
- R11: When `illegal` is 1, `ea` is 0 and `seg_stack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode32 | input | 1 | 1 = 32-bit mode, 0 = 16-bit mode |
| base_vld | input | 1 | Base register present |
| base_sel | input | 3 | Base register code |
| index_vld | input | 1 | Index register present |
| index_sel | input | 3 | Index register code |
| scale | input | 2 | Index scale code |
| disp | input | 32 | Raw displacement |
| disp_size | input | 2 | Displacement size code |
| rf_base_idx | output | 3 | Register-file read address for the base |
| rf_base_data | input | 32 | Register-file read data for the base |
| rf_index_idx | output | 3 | Register-file read address for the index |
| rf_index_data | input | 32 | Register-file read data for the index |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective offset |
| seg_stack | output | 1 | 1 = stack segment, 0 = data segment |
| illegal | output | 1 | Illegal register or scale combination |

## Verification
Rule checking and segment selection act on the same request, so a single strobe can both pick the stack segment and be illegal. This case is provoked two ways. In 16-bit mode, a BP base is paired with a nonzero scale or with a non-SI/DI index. In 32-bit mode, an SP or BP base is paired with an SP index. An exhaustive sweep over mode, presence flags, register codes and scale codes creates all such overlaps, and random displacements and register values fill in the rest. The outcome is judged against a bench model: a zero offset with the data segment, not the stack choice that the base alone would give.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // general register codes; the legality and segment rules depend on them
    typedef enum logic [2:0] {
        GPR_A  = 3'd0,
        GPR_C  = 3'd1,
        GPR_D  = 3'd2,
        GPR_B  = 3'd3,
        GPR_SP = 3'd4,
        GPR_BP = 3'd5,
        GPR_SI = 3'd6,
        GPR_DI = 3'd7
    } gpr_e;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_8    = 2'd1,
        DSZ_16   = 2'd2,
        DSZ_FULL = 2'd3
    } dsz_e;

    typedef enum logic {
        SEG_DATA  = 1'b0,
        SEG_STACK = 1'b1
    } seg_e;

    typedef struct packed {
        logic bad_base;
        logic bad_index;
        logic bad_scale;
    } viol_t;

    localparam int unsigned NUM_DSZ_EXT = 3;

    function automatic logic base_allowed(input logic wide, input gpr_e sel);
        if (wide) return 1'b1;
        return (sel == GPR_B) || (sel == GPR_BP);
    endfunction

    function automatic logic index_allowed(input logic wide, input gpr_e sel);
        if (wide) return sel != GPR_SP;
        return (sel == GPR_SI) || (sel == GPR_DI);
    endfunction

    function automatic seg_e base_segment(input logic wide, input logic present,
                                          input gpr_e sel);
        if (!present) return SEG_DATA;
        if (sel == GPR_BP) return SEG_STACK;
        if (wide && sel == GPR_SP) return SEG_STACK;
        return SEG_DATA;
    endfunction

endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] disp,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] ext
);
    logic [ADDR_W-1:0] cand [NUM_DSZ_EXT];

    // one sign-extension variant per encoded size, widths 8 << g
    for (genvar g = 0; g < NUM_DSZ_EXT; g++) begin : g_sz
        localparam int unsigned WD = 8 << g;
        if (WD < ADDR_W) begin : g_ext
            assign cand[g] = {{(ADDR_W-WD){disp[WD-1]}}, disp[WD-1:0]};
        end else begin : g_full
            assign cand[g] = disp;
        end
    end

    always_comb begin
        unique case (dsz_e'(size))
            DSZ_NONE: ext = '0;
            DSZ_8:    ext = cand[0];
            DSZ_16:   ext = cand[1];
            DSZ_FULL: ext = cand[2];
            default:  ext = '0;
        endcase
    end
endmodule

// File: rtl/agu_operand.sv
module agu_operand #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic              wide,
    input  logic              present,
    input  logic [ADDR_W-1:0] value,
    input  logic [1:0]        shamt,
    output logic [ADDR_W-1:0] term
);
    localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [ADDR_W-1:0] trimmed;

    always_comb begin
        trimmed = wide ? value : (value & NARROW_MASK);
        term    = present ? (trimmed << shamt) : '0;
    end
endmodule

// File: rtl/agu_rules.sv
module agu_rules
    import agu_pkg::*;
(
    input  logic       wide,
    input  logic       base_vld,
    input  logic [2:0] base_sel,
    input  logic       index_vld,
    input  logic [2:0] index_sel,
    input  logic [1:0] scale,
    output viol_t      viol,
    output logic       bad,
    output seg_e       seg
);
    always_comb begin
        viol.bad_base  = base_vld  && !base_allowed(wide, gpr_e'(base_sel));
        viol.bad_index = index_vld && !index_allowed(wide, gpr_e'(index_sel));
        viol.bad_scale = !wide && (scale != 2'd0);
        bad            = |viol;
        seg            = bad ? SEG_DATA : base_segment(wide, base_vld, gpr_e'(base_sel));
    end
endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic              wide,
    input  logic              bad,
    input  logic [ADDR_W-1:0] base_term,
    input  logic [ADDR_W-1:0] index_term,
    input  logic [ADDR_W-1:0] disp_term,
    output logic [ADDR_W-1:0] result
);
    localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw = base_term + index_term + disp_term;
        if (bad)
            result = '0;
        else if (wide)
            result = raw;
        else
            result = raw & NARROW_MASK;
    end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode32,
    input  logic              base_vld,
    input  logic [2:0]        base_sel,
    input  logic              index_vld,
    input  logic [2:0]        index_sel,
    input  logic [1:0]        scale,
    input  logic [ADDR_W-1:0] disp,
    input  logic [1:0]        disp_size,
    output logic [2:0]        rf_base_idx,
    input  logic [ADDR_W-1:0] rf_base_data,
    output logic [2:0]        rf_index_idx,
    input  logic [ADDR_W-1:0] rf_index_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              seg_stack,
    output logic              illegal
);
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] disp_term;
    logic [ADDR_W-1:0] sum_next;
    viol_t             viol;
    logic              bad;
    seg_e              seg_next;

    assign rf_base_idx  = base_sel;
    assign rf_index_idx = index_sel;

    agu_operand #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_base_op (
        .wide    (mode32),
        .present (base_vld),
        .value   (rf_base_data),
        .shamt   (2'd0),
        .term    (base_term)
    );

    agu_operand #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_index_op (
        .wide    (mode32),
        .present (index_vld),
        .value   (rf_index_data),
        .shamt   (scale),
        .term    (index_term)
    );

    agu_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
        .disp (disp),
        .size (disp_size),
        .ext  (disp_term)
    );

    agu_rules u_rules (
        .wide      (mode32),
        .base_vld  (base_vld),
        .base_sel  (base_sel),
        .index_vld (index_vld),
        .index_sel (index_sel),
        .scale     (scale),
        .viol      (viol),
        .bad       (bad),
        .seg       (seg_next)
    );

    agu_sum #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_sum (
        .wide       (mode32),
        .bad        (bad),
        .base_term  (base_term),
        .index_term (index_term),
        .disp_term  (disp_term),
        .result     (sum_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ea        <= '0;
            seg_stack <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ea        <= sum_next;
                seg_stack <= (seg_next == SEG_STACK);
                illegal   <= viol.bad_base | viol.bad_index | viol.bad_scale;
            end
        end
    end
endmodule

// File: rtl/agu_check.sv
module agu_check #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              mode32,
    input logic              base_vld,
    input logic [2:0]        base_sel,
    input logic              index_vld,
    input logic [2:0]        index_sel,
    input logic [1:0]        scale,
    input logic              out_valid,
    input logic [ADDR_W-1:0] ea,
    input logic              seg_stack,
    input logic              illegal
);
    assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(ea) && $stable(seg_stack) && $stable(illegal)));

    assert_narrow_regs_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode32 && ((base_vld && base_sel != 3'd3 && base_sel != 3'd5) ||
                                 (index_vld && index_sel != 3'd6 && index_sel != 3'd7)))
        |=> illegal);

    assert_narrow_scale_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode32 && scale != 2'd0) |=> illegal);

    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode32) |=> (ea[ADDR_W-1:NARROW_W] == '0));

    assert_sp_index_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode32 && index_vld && index_sel == 3'd4) |=> illegal);

    assert_wide_legal_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode32 && !(index_vld && index_sel == 3'd4)) |=> !illegal);

    assert_wide_stack_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode32 && base_vld && (base_sel == 3'd4 || base_sel == 3'd5))
        |=> (seg_stack || illegal));

    assert_narrow_stack_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode32 && base_vld && base_sel == 3'd4) |=> !seg_stack);

    assert_nobase_data_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !base_vld) |=> !seg_stack);

    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (ea == '0 && !seg_stack));
endmodule

bind addr_gen_unit agu_check #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_agu_check (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode32    (mode32),
    .base_vld  (base_vld),
    .base_sel  (base_sel),
    .index_vld (index_vld),
    .index_sel (index_sel),
    .scale     (scale),
    .out_valid (out_valid),
    .ea        (ea),
    .seg_stack (seg_stack),
    .illegal   (illegal)
);

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        mode32 = 1'b0;
    logic        base_vld = 1'b0;
    logic [2:0]  base_sel = '0;
    logic        index_vld = 1'b0;
    logic [2:0]  index_sel = '0;
    logic [1:0]  scale = '0;
    logic [31:0] disp = '0;
    logic [1:0]  disp_size = '0;
    logic [2:0]  rf_base_idx, rf_index_idx;
    logic [31:0] rf_base_data, rf_index_data;
    logic        out_valid, seg_stack, illegal;
    logic [31:0] ea;
    logic [31:0] regs [8];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign rf_base_data  = regs[rf_base_idx];
    assign rf_index_data = regs[rf_index_idx];

    addr_gen_unit i_addr_gen_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode32(mode32),
        .base_vld(base_vld), .base_sel(base_sel), .index_vld(index_vld),
        .index_sel(index_sel), .scale(scale), .disp(disp), .disp_size(disp_size),
        .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
        .rf_index_idx(rf_index_idx), .rf_index_data(rf_index_data),
        .out_valid(out_valid), .ea(ea), .seg_stack(seg_stack), .illegal(illegal)
    );

    // {illegal, stack, offset}
    function automatic logic [33:0] model(input logic m32, input logic bv, input logic [2:0] bs,
                                          input logic iv, input logic [2:0] is, input logic [1:0] sc,
                                          input logic [31:0] d, input logic [1:0] dsz);
        logic ill, stk;
        logic [31:0] bval, ival, dval, sum;
        if (m32) ill = iv && (is == 3'd4);
        else ill = (bv && bs != 3'd3 && bs != 3'd5) || (iv && is != 3'd6 && is != 3'd7) || (sc != 2'd0);
        stk = !ill && bv && ((bs == 3'd5) || (m32 && bs == 3'd4));
        case (dsz)
            2'd0: dval = 32'd0;
            2'd1: dval = {{24{d[7]}}, d[7:0]};
            2'd2: dval = {{16{d[15]}}, d[15:0]};
            default: dval = d;
        endcase
        bval = bv ? regs[bs] : 32'd0;
        ival = iv ? regs[is] : 32'd0;
        if (!m32) begin
            bval = bval & 32'h0000_FFFF;
            ival = ival & 32'h0000_FFFF;
        end
        sum = bval + ival * (32'd1 << sc) + dval;
        if (!m32) sum = sum & 32'h0000_FFFF;
        if (ill) sum = 32'd0;
        return {ill, stk, sum};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    logic [33:0] last_exp;

    task automatic apply(input logic m32, input logic bv, input logic [2:0] bs,
                         input logic iv, input logic [2:0] is, input logic [1:0] sc,
                         input logic [31:0] d, input logic [1:0] dsz);
        logic [33:0] e;
        string ta, ts, ti;
        @(negedge clk);
        mode32 = m32; base_vld = bv; base_sel = bs; index_vld = iv; index_sel = is;
        scale = sc; disp = d; disp_size = dsz; in_valid = 1'b1;
        e = model(m32, bv, bs, iv, is, sc, d, dsz);
        last_exp = e;
        @(negedge clk);
        in_valid = 1'b0;
        ti = m32 ? "R7" : "R5";
        ta = e[33] ? "R11" : (m32 ? "R2" : "R6");
        ts = e[33] ? "R11" : (!bv ? "R10" : (m32 ? "R8" : "R9"));
        check({"R1 out_valid"}, {31'd0, out_valid}, 32'd1);
        check({ti, " illegal"}, {31'd0, illegal}, {31'd0, e[33]});
        check({ts, " seg_stack"}, {31'd0, seg_stack}, {31'd0, e[32]});
        check({ta, " ea"}, ea, e[31:0]);
    endtask

    task automatic randomize_regs();
        for (int k = 0; k < 8; k++) regs[k] = $urandom;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) regs[k] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset ea", ea, 32'd0);
        check("R1 reset seg", {31'd0, seg_stack}, 32'd0);
        check("R1 reset illegal", {31'd0, illegal}, 32'd0);

        // R3 displacement sizes, literal expectations
        apply(1, 0, 0, 0, 0, 0, 32'hABCD_1280, 2'd1);
        check("R3 disp8", ea, 32'hFFFF_FF80);
        apply(1, 0, 0, 0, 0, 0, 32'h0000_9234, 2'd2);
        check("R3 disp16", ea, 32'hFFFF_9234);
        apply(1, 0, 0, 0, 0, 0, 32'h8765_4321, 2'd0);
        check("R3 disp none", ea, 32'd0);
        apply(1, 0, 0, 0, 0, 0, 32'h8765_4321, 2'd3);
        check("R3 disp32", ea, 32'h8765_4321);

        // R4 scale by 8
        regs[0] = 32'h0000_0010;
        apply(1, 0, 0, 1, 0, 2'd3, 32'd0, 2'd0);
        check("R4 scale8", ea, 32'h0000_0080);

        // R6 narrow wrap with upper junk
        regs[3] = 32'h1234_FFF0; regs[6] = 32'hABCD_0020;
        apply(0, 1, 3'd3, 1, 3'd6, 0, 32'd0, 2'd0);
        check("R6 narrow wrap", ea, 32'h0000_0010);

        // R2 wide wrap
        regs[1] = 32'hFFFF_FFF0; regs[2] = 32'h0000_0008;
        apply(1, 1, 3'd1, 1, 3'd2, 2'd1, 32'h0000_0001, 2'd1);
        check("R2 wide wrap", ea, 32'h0000_0001);

        // R10 no base, BP index
        apply(1, 0, 0, 1, 3'd5, 2'd1, 32'd4, 2'd1);
        check("R10 index BP data seg", {31'd0, seg_stack}, 32'd0);

        // R8 SP base gives stack
        apply(1, 1, 3'd4, 0, 0, 0, 32'd0, 2'd0);
        check("R8 SP base stack", {31'd0, seg_stack}, 32'd1);

        // R11 overlap: BP base would pick stack but scale is illegal
        regs[5] = 32'h0000_1000;
        apply(0, 1, 3'd5, 1, 3'd6, 2'd1, 32'd0, 2'd0);
        check("R11 overlap illegal", {31'd0, illegal}, 32'd1);
        check("R11 overlap ea", ea, 32'd0);
        check("R11 overlap seg", {31'd0, seg_stack}, 32'd0);
        // R9 legal BP base
        apply(0, 1, 3'd5, 1, 3'd7, 2'd0, 32'd0, 2'd0);
        check("R9 BP stack", {31'd0, seg_stack}, 32'd1);

        // R1 hold: inputs change without strobe
        @(negedge clk);
        mode32 = 1'b1; base_vld = 1'b1; base_sel = 3'd0; index_vld = 1'b1; index_sel = 3'd4;
        disp = 32'h5555_5555; disp_size = 2'd3;
        @(negedge clk);
        check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 idle hold ea", ea, last_exp[31:0]);
        check("R1 idle hold illegal", {31'd0, illegal}, {31'd0, last_exp[33]});

        // exhaustive sweep over register, presence and scale choices
        for (int m = 0; m < 2; m++)
            for (int bv = 0; bv < 2; bv++)
                for (int b = 0; b < 8; b++)
                    for (int iv = 0; iv < 2; iv++)
                        for (int i = 0; i < 8; i++)
                            for (int s = 0; s < 4; s++) begin
                                randomize_regs();
                                apply(m[0], bv[0], b[2:0], iv[0], i[2:0], s[1:0],
                                      $urandom, 2'($urandom));
                            end

        // random requests
        for (int n = 0; n < 400; n++) begin
            randomize_regs();
            apply(1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
                  2'($urandom), $urandom, 2'($urandom));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule